// File: doc/BRIEF.md
# Reference Source Selection Controller

This block decides which input reference feeds a clock synthesizer: an external single-ended clock (REF) or a local crystal oscillator. A monitor running on a free-running monitor clock watches REF for activity. While activity is seen, the controller routes REF to the reference output and turns the crystal oscillator off. A mode bit lets software force the crystal path whatever REF is doing. Switching between the two sources goes through a glitch-free clock multiplexer. Each branch gate closes on a low phase of its own clock, and the other gate opens only after that.

The same block produces the 6-bit crystal load-trim code. One step of the code is 0.25 pF on top of a fixed 13 pF. A control bit chooses the code source. When the bit is set, the hardwired default code 8 is used, which gives 2 pF and a 15 pF total. When it is clear, the programmed field is used. That field resets to all ones, so clearing the control bit alone gives code 63 until the field is rewritten. A byte-wide write port with a combinational read port holds the two control registers.

Top module: `refsel_top`

## Requirements
- R1: After reset the outputs read as follows. refPresent is 0, refSelected is 0 and xoEn is 1. trimCode is 8. Register 0x1B reads 0xBF, with bit 7 set and bits [5:0] all ones. Register 0x1D reads 0x00.
- R2: REF is declared present after 4 REF rising edges are counted within one 64-cycle monitor window. Edges are taken through a two-flop synchronizer. A REF clock with a period of 30 monitor cycles, which gives at most 3 edges per window, never sets refPresent.
- R3: REF is declared lost once 64 monitor cycles pass with no REF rising edge. Before that, refPresent stays set.
- R4: When REF is present and register 0x1D bit 0 is 0, refSelected is 1. xoEn then falls, but only after the crystal branch gate has closed.
- R5: Writing 1 to register 0x1D bit 0 forces refSelected to 0 and xoEn to 1 from the cycle after the write. refPresent still reports the raw presence state. Clearing the bit restores automatic selection.
- R6: Register 0x1B bit 7 selects the trim source: 1 drives the default code 8 on trimCode, and 0 drives bits [5:0] of the register. Bit 6 has no effect on trimCode.
- R7: A read of 0x1B returns the whole stored byte. A read of 0x1D returns bit 0 and zeros above it. A read of any other address returns 0. A write to any other address changes neither register.
- R8: Once the gates have settled, refClkOut follows REF while REF is selected and follows the crystal clock while the crystal is selected. If REF is lost, its gate is cleared without any REF edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| monClk | input | 1 | Free-running monitor and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | External single-ended reference clock |
| xtalIn | input | 1 | Crystal oscillator clock |
| wrEn | input | 1 | Register write strobe, sampled on monClk |
| addr | input | 8 | Register address for write and read |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Combinational read data for addr |
| refClkOut | output | 1 | Selected reference clock |
| xoEn | output | 1 | Crystal oscillator enable |
| refSelected | output | 1 | Current selection, 1 = REF, 0 = crystal |
| refPresent | output | 1 | Raw REF presence flag |
| trimCode | output | 6 | Crystal load-trim code |

## Verification
A register write shows on trimCode and rdData one monitor cycle after the write edge. refSelected and xoEn respond to the override bit in that same cycle, so the bench samples them on the falling monitor edge right after the write. A REF edge reaches the presence flag three monitor edges after it arrives, and loss comes about 65 cycles after the last edge. The bench drives REF in whole monitor cycles and checks only at points well clear of those limits: 3 cycles after the start for absence, 100 cycles for presence, 40 idle cycles for "still present" and 100 for "lost". The gating of refClkOut and the fall of xoEn cross the asynchronous crystal domain, so they are checked after a 30-cycle settle, with refClkOut sampled mid-phase of the clock it is expected to follow.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int TRIM_W = 6;
  localparam logic [TRIM_W-1:0] TRIM_HW_DEF = 6'd8;
  localparam logic [7:0] ADDR_TRIM = 8'h1B;
  localparam logic [7:0] ADDR_MODE = 8'h1D;

  // control-to-datapath strobes
  typedef struct packed {
    logic              wantRef;
    logic              present;
    logic              useHwTrim;
    logic [TRIM_W-1:0] trimProg;
  } ctlStrb_t;

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/refsel_presence.sv
module refsel_presence #(
  parameter int WIN_CYC     = 64,
  parameter int ACQ_EDGES   = 4,
  parameter int LOSS_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic monClk,
  input  logic rstN,
  input  logic refIn,
  output logic present
);

  localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EC_W   = $clog2(ACQ_EDGES + 1);
  localparam int IDLE_W = $clog2(LOSS_CYC + 1);

  logic              refSync;
  logic              refLast;
  logic              edgeSeen;
  logic [WIN_W-1:0]  winCnt;
  logic [EC_W-1:0]   edgeCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              winEnd;

  refsel_sync #(.STAGES(SYNC_STAGES)) refSync_i (
    .clk  (monClk),
    .rstN (rstN),
    .dIn  (refIn),
    .qOut (refSync)
  );

  assign edgeSeen = refSync & ~refLast;
  assign winEnd   = (winCnt == WIN_W'(WIN_CYC - 1));

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      refLast <= 1'b0;
      winCnt  <= '0;
      edgeCnt <= '0;
      idleCnt <= '0;
      present <= 1'b0;
    end else begin
      refLast <= refSync;

      if (winEnd) winCnt <= '0;
      else        winCnt <= winCnt + 1'b1;

      if (winEnd)
        edgeCnt <= '0;
      else if (edgeSeen && edgeCnt != EC_W'(ACQ_EDGES))
        edgeCnt <= edgeCnt + 1'b1;

      if (edgeSeen)
        idleCnt <= '0;
      else if (idleCnt != IDLE_W'(LOSS_CYC))
        idleCnt <= idleCnt + 1'b1;

      if (edgeSeen && edgeCnt == EC_W'(ACQ_EDGES - 1))
        present <= 1'b1;
      else if (!edgeSeen && idleCnt == IDLE_W'(LOSS_CYC - 1))
        present <= 1'b0;
    end
  end

endmodule

// File: rtl/refsel_clkgate.sv
module refsel_clkgate (
  input  logic clkIn,
  input  logic kill,
  input  logic req,
  output logic gate
);

  logic meta;

  // enable moves only on the low phase of its own clock
  always_ff @(negedge clkIn or posedge kill) begin
    if (kill) begin
      meta <= 1'b0;
      gate <= 1'b0;
    end else begin
      meta <= req;
      gate <= meta;
    end
  end

endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int WIN_CYC     = 64,
  parameter int ACQ_EDGES   = 4,
  parameter int LOSS_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              monClk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output ctlStrb_t          strb
);

  localparam logic [DATA_W-1:0] TRIM_RST =
    {1'b1, {(DATA_W-1-TRIM_W){1'b0}}, {TRIM_W{1'b1}}};

  logic [DATA_W-1:0] trimReg;
  logic              ovrReg;
  logic              present;
  logic              hitTrim;
  logic              hitMode;

  refsel_presence #(
    .WIN_CYC     (WIN_CYC),
    .ACQ_EDGES   (ACQ_EDGES),
    .LOSS_CYC    (LOSS_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) presence_i (
    .monClk  (monClk),
    .rstN    (rstN),
    .refIn   (refIn),
    .present (present)
  );

  assign hitTrim = (addr == ADDR_W'(ADDR_TRIM));
  assign hitMode = (addr == ADDR_W'(ADDR_MODE));

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) begin
      trimReg <= TRIM_RST;
      ovrReg  <= 1'b0;
    end else if (wrEn) begin
      if (hitTrim) trimReg <= wrData;
      if (hitMode) ovrReg  <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (hitTrim)      rdData = trimReg;
    else if (hitMode) rdData = {{(DATA_W-1){1'b0}}, ovrReg};
  end

  always_comb begin
    strb.wantRef   = present & ~ovrReg;
    strb.present   = present;
    strb.useHwTrim = trimReg[DATA_W-1];
    strb.trimProg  = trimReg[TRIM_W-1:0];
  end

endmodule

// File: rtl/refsel_dp.sv
module refsel_dp
  import refsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              monClk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              xtalIn,
  input  ctlStrb_t          strb,
  output logic              refClkOut,
  output logic              xoEn,
  output logic [TRIM_W-1:0] trimCode
);

  logic refGate;
  logic xtalGate;
  logic refReq;
  logic xtalReq;
  logic refKill;
  logic xtalKill;
  logic xtalGateMon;

  // each side asks to open only while the other side is shut
  assign refReq   = strb.wantRef & ~xtalGate;
  assign xtalReq  = ~strb.wantRef & ~refGate;
  // a lost REF cannot clock its own gate shut, so clear it directly
  assign refKill  = ~rstN | ~strb.present;
  assign xtalKill = ~rstN;

  refsel_clkgate refGate_i (
    .clkIn (refIn),
    .kill  (refKill),
    .req   (refReq),
    .gate  (refGate)
  );

  refsel_clkgate xtalGate_i (
    .clkIn (xtalIn),
    .kill  (xtalKill),
    .req   (xtalReq),
    .gate  (xtalGate)
  );

  assign refClkOut = (refIn & refGate) | (xtalIn & xtalGate);

  refsel_sync #(.STAGES(SYNC_STAGES)) xtalGateSync_i (
    .clk  (monClk),
    .rstN (rstN),
    .dIn  (xtalGate),
    .qOut (xtalGateMon)
  );

  // oscillator stays on until its branch of the mux has let go
  assign xoEn = ~strb.wantRef | xtalGateMon;

  assign trimCode = strb.useHwTrim ? TRIM_HW_DEF : strb.trimProg;

endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int WIN_CYC     = 64,
  parameter int ACQ_EDGES   = 4,
  parameter int LOSS_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              monClk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              xtalIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              refClkOut,
  output logic              xoEn,
  output logic              refSelected,
  output logic              refPresent,
  output logic [TRIM_W-1:0] trimCode
);

  ctlStrb_t strb;

  refsel_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WIN_CYC     (WIN_CYC),
    .ACQ_EDGES   (ACQ_EDGES),
    .LOSS_CYC    (LOSS_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .monClk (monClk),
    .rstN   (rstN),
    .refIn  (refIn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .strb   (strb)
  );

  refsel_dp #(
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .monClk    (monClk),
    .rstN      (rstN),
    .refIn     (refIn),
    .xtalIn    (xtalIn),
    .strb      (strb),
    .refClkOut (refClkOut),
    .xoEn      (xoEn),
    .trimCode  (trimCode)
  );

  assign refSelected = strb.wantRef;
  assign refPresent  = strb.present;

endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
  import refsel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              monClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              xoEn,
  input logic              refSelected,
  input logic              refPresent,
  input logic [TRIM_W-1:0] trimCode
);

  // R6
  trim_def_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_TRIM) && wrData[DATA_W-1]) |=> (trimCode == TRIM_HW_DEF));

  // R6
  trim_prog_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_TRIM) && !wrData[DATA_W-1])
      |=> (trimCode == $past(wrData[TRIM_W-1:0])));

  // R5
  ovr_force_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_MODE) && wrData[0]) |=> (!refSelected && xoEn));

  // R4
  sel_needs_ref_chk: assert property (@(posedge monClk) disable iff (!rstN)
    refSelected |-> refPresent);

  // R7
  mode_rd_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (addr == ADDR_W'(ADDR_MODE)) |-> (rdData[DATA_W-1:1] == '0));

  // R7
  trim_rd_chk: assert property (@(posedge monClk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(ADDR_TRIM))
      |=> (addr != ADDR_W'(ADDR_TRIM) || rdData == $past(wrData)));

endmodule

bind refsel_top refsel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .monClk      (monClk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .addr        (addr),
  .wrData      (wrData),
  .rdData      (rdData),
  .xoEn        (xoEn),
  .refSelected (refSelected),
  .refPresent  (refPresent),
  .trimCode    (trimCode)
);

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;

  logic       monClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       refIn  = 1'b0;
  logic       xtalIn = 1'b0;
  logic       wrEn   = 1'b0;
  logic [7:0] addr   = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       refClkOut;
  logic       xoEn;
  logic       refSelected;
  logic       refPresent;
  logic [5:0] trimCode;

  int  nChk = 0;
  int  nFail = 0;
  int  refHalf = 2;
  int  refPh = 0;
  bit  refRun = 1'b0;

  refsel_top dut_i (
    .monClk      (monClk),
    .rstN        (rstN),
    .refIn       (refIn),
    .xtalIn      (xtalIn),
    .wrEn        (wrEn),
    .addr        (addr),
    .wrData      (wrData),
    .rdData      (rdData),
    .refClkOut   (refClkOut),
    .xoEn        (xoEn),
    .refSelected (refSelected),
    .refPresent  (refPresent),
    .trimCode    (trimCode)
  );

  always #4 monClk = ~monClk;   // 125 MHz
  always #7 xtalIn = ~xtalIn;

  // REF generator, in whole monitor cycles
  initial begin
    forever begin
      @(negedge monClk);
      if (refRun) begin
        refPh++;
        if (refPh >= refHalf) begin
          refPh = 0;
          refIn = ~refIn;
        end
      end
    end
  end

  typedef struct packed {
    logic [7:0] vAddr;
    logic [7:0] vData;
    logic [5:0] expTrim;
    logic [7:0] expRd;
  } vec_t;

  // R6 / R7 register vectors, applied in order from reset
  localparam vec_t VECS [7] = '{
    '{8'h1B, 8'h85, 6'd8,  8'h85},  // R6 bit7 set: default code
    '{8'h1B, 8'h05, 6'd5,  8'h05},  // R6 programmed field
    '{8'h1B, 8'h7F, 6'd63, 8'h7F},  // R6 bit6 no effect
    '{8'h1B, 8'h00, 6'd0,  8'h00},  // R6 zero field
    '{8'h20, 8'hFF, 6'd0,  8'h00},  // R7 other address ignored
    '{8'h1D, 8'hFE, 6'd0,  8'h00},  // R7 only bit0 stored
    '{8'h1B, 8'hC0, 6'd8,  8'hC0}   // R6 back to default
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge monClk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge monClk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge monClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge monClk);
    addr = a;
    #1 d = rdData;
  endtask

  // count cycles where refClkOut differs from the crystal clock mid-phase
  task automatic followXtal(output int bad);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge xtalIn); #2; if (refClkOut !== 1'b1) bad++;
      @(negedge xtalIn); #2; if (refClkOut !== 1'b0) bad++;
    end
  endtask

  task automatic followRef(output int bad);
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(posedge monClk); #1; if (refClkOut !== refIn) bad++;
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int bad;

    cycles(3);
    rstN = 1'b1;
    cycles(4);

    // R1 reset state
    check("R1 refPresent", refPresent, 0);
    check("R1 refSelected", refSelected, 0);
    check("R1 xoEn", xoEn, 1);
    check("R1 trimCode", trimCode, 8);
    rd(8'h1B, d); check("R1 trim reg 0xBF", d, 8'hBF);
    rd(8'h1D, d); check("R1 mode reg", d, 8'h00);

    // R6 / R7 vector table
    for (int i = 0; i < 7; i++) begin
      wr(VECS[i].vAddr, VECS[i].vData);
      check("R6 trimCode", trimCode, VECS[i].expTrim);
      rd(VECS[i].vAddr, d);
      check("R7 readback", d, VECS[i].expRd);
    end
    rd(8'h1B, d); check("R7 trim reg after ignored write", d, 8'hC0);

    // R8 crystal path after reset
    followXtal(bad); check("R8 follows crystal", bad, 0);

    // R2 sparse REF: at most 3 edges per window
    refHalf = 15; refRun = 1'b1;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge monClk); #1;
      if (refPresent !== 1'b0) bad++;
    end
    check("R2 sparse REF not present", bad, 0);
    refRun = 1'b0; refIn = 1'b0; refPh = 0;
    cycles(70);

    // R2 fast REF
    refHalf = 2; refRun = 1'b1;
    cycles(3);
    check("R2 not yet present", refPresent, 0);
    cycles(100);
    check("R2 present", refPresent, 1);
    // R4 automatic preference
    check("R4 refSelected", refSelected, 1);
    cycles(30);
    check("R4 xoEn off", xoEn, 0);
    followRef(bad); check("R8 follows REF", bad, 0);

    // R5 override
    wr(8'h1D, 8'h01);
    check("R5 refSelected forced 0", refSelected, 0);
    check("R5 xoEn forced 1", xoEn, 1);
    check("R5 raw presence kept", refPresent, 1);
    rd(8'h1D, d); check("R7 mode read", d, 8'h01);
    cycles(30);
    followXtal(bad); check("R8 follows crystal under override", bad, 0);
    wr(8'h1D, 8'h00);
    check("R5 release refSelected", refSelected, 1);
    cycles(30);
    check("R4 xoEn off again", xoEn, 0);

    // R3 loss
    @(negedge monClk);
    refRun = 1'b0; refIn = 1'b0;
    cycles(40);
    check("R3 still present", refPresent, 1);
    cycles(60);
    check("R3 lost", refPresent, 0);
    check("R3 refSelected", refSelected, 0);
    check("R3 xoEn", xoEn, 1);
    cycles(30);
    followXtal(bad); check("R8 crystal after loss", bad, 0);

    finishRun();
  end

endmodule